// File: doc/BRIEF.md
# Dual-Rail Hysteresis Gate Array with Completion Acknowledge

This block is a cycle-based, synthesizable model of a small self-timed datapath built from dual-rail gates that hold their state. Each lane carries three dual-rail operands `a`, `b` and `c` and produces one dual-rail result. Bit `i` uses rails `[2i+1:2i]`. The encoding is 2'b00 = empty (spacer), 2'b01 = TRUE, 2'b10 = FALSE and 2'b11 = illegal. Each lane computes `y = (a AND b) OR (NOT c)`.

The AND and OR gates are registered hysteresis gates. Such a gate moves to a data value only once all of its inputs carry data. It moves back to the spacer only once all of its inputs are empty. In any other case it keeps its previous output. The inverter swaps the two rails, so it passes the spacer through unchanged. A completion detector watches the whole result word and reports when every lane holds data or when every lane is empty. A registered acknowledge follows these two reports and forms a four-phase return-to-zero handshake toward the source. Any illegal 2'b11 code on an input sets a sticky error flag.

Top module: `dr_gate_array`

## Requirements
- R1: After synchronous reset, `y_out` is all 2'b00, `null_done` is 1, and `data_done`, `ack` and `err` are 0.
- R2: Once every input pair of a lane holds data, that lane settles within two clocks to `(a AND b) OR (NOT c)`, encoded as TRUE = 2'b01 and FALSE = 2'b10.
- R3: A lane output that is empty stays empty while any of its inputs is still empty.
- R4: A lane output that holds data stays unchanged while only some of its inputs have returned to 2'b00. It returns to 2'b00 within two clocks once all of its inputs are empty.
- R5: The inverting path turns TRUE into FALSE and FALSE into TRUE. With `a` and `b` both FALSE, each lane result equals NOT `c`.
- R6: `data_done` is 1 exactly when every lane of `y_out` holds data. `null_done` is 1 exactly when every lane is 2'b00. A word that mixes data and empty lanes drives both low.
- R7: `ack` rises one clock after `data_done` is seen and falls one clock after `null_done` is seen. At all other times it holds its value.
- R8: A 2'b11 on any input pair sets `err`, which stays set until reset. A gate that sees 2'b11 on one of its inputs holds its output.
- R9: Between two consecutive clocks, a lane of `y_out` changes at most one rail and never shows 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 2*NBITS | Dual-rail operand a, one pair per lane |
| b_in | input | 2*NBITS | Dual-rail operand b, one pair per lane |
| c_in | input | 2*NBITS | Dual-rail operand c (inverted path) |
| y_out | output | 2*NBITS | Dual-rail result word |
| data_done | output | 1 | All result lanes hold data |
| null_done | output | 1 | All result lanes are empty |
| ack | output | 1 | Four-phase acknowledge toward the source |
| err | output | 1 | Sticky flag for an illegal input code |

## Verification
The hardest situations to reach are the states where some inputs have arrived and others lag behind. In these states the gates must hold, both on the way into data and on the way back to empty. The bench emulates unequal rail delays by driving `a`, `b` and `c` in separate steps with idle clocks between them. It checks that the result and the acknowledge stay put until the last operand arrives. It also drives data into one lane only to produce a word that mixes data and empty lanes. Finally, it injects an illegal code into a lane that already holds data to show that the gate holds its output.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef logic [1:0] dr_t;

  localparam dr_t DR_NULL  = 2'b00;
  localparam dr_t DR_TRUE  = 2'b01;
  localparam dr_t DR_FALSE = 2'b10;
  localparam dr_t DR_BAD   = 2'b11;

  typedef enum logic {OP_AND, OP_OR} th_op_e;

  function automatic logic dr_is_data(dr_t v);
    return (v == DR_TRUE) || (v == DR_FALSE);
  endfunction

  function automatic dr_t dr_from_bool(logic v);
    return v ? DR_TRUE : DR_FALSE;
  endfunction
endpackage

// File: rtl/dr_inv.sv
module dr_inv
  import dr_pkg::*;
(
  input  dr_t x,
  output dr_t y
);
  // swapping the rails exchanges TRUE and FALSE; spacer and illegal map to themselves
  assign y = {x[0], x[1]};
endmodule

// File: rtl/dr_th_gate.sv
module dr_th_gate
  import dr_pkg::*;
#(
  parameter th_op_e OP = OP_AND
) (
  input  logic clk,
  input  logic rst,
  input  dr_t  x0,
  input  dr_t  x1,
  output dr_t  y
);
  logic v0, v1, fn;
  logic both_data, both_null, any_bad;
  dr_t  y_q, y_d;

  assign v0 = (x0 == DR_TRUE);
  assign v1 = (x1 == DR_TRUE);

  generate
    if (OP == OP_AND) begin : g_and
      assign fn = v0 & v1;
    end else begin : g_or
      assign fn = v0 | v1;
    end
  endgenerate

  always_comb begin
    both_data = dr_is_data(x0) && dr_is_data(x1);
    both_null = (x0 == DR_NULL) && (x1 == DR_NULL);
    any_bad   = (x0 == DR_BAD) || (x1 == DR_BAD);
    y_d       = y_q;
    if (!any_bad) begin
      if (both_data)      y_d = dr_from_bool(fn);
      else if (both_null) y_d = DR_NULL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) y_q <= DR_NULL;
    else     y_q <= y_d;
  end

  assign y = y_q;

  // R3 R4
  property hold_on_mixed_p;
    @(posedge clk) disable iff (rst)
      (!both_data && !both_null) |=> $stable(y_q);
  endproperty
  hold_on_mixed_chk: assert property (hold_on_mixed_p);

  // R3
  property leave_null_p;
    @(posedge clk) disable iff (rst)
      ((y_q != $past(y_q)) && ($past(y_q) == DR_NULL)) |-> $past(both_data);
  endproperty
  leave_null_chk: assert property (leave_null_p);

  // R9
  property one_rail_p;
    @(posedge clk) disable iff (rst)
      ($countones(y_q ^ $past(y_q)) <= 1) && (y_q != DR_BAD);
  endproperty
  one_rail_chk: assert property (one_rail_p);
endmodule

// File: rtl/dr_completion.sv
module dr_completion
  import dr_pkg::*;
#(
  parameter int NBITS = 4
) (
  input  logic [2*NBITS-1:0] word,
  output logic               all_data,
  output logic               all_null
);
  logic [NBITS-1:0] lane_data, lane_null;

  generate
    for (genvar i = 0; i < NBITS; i++) begin : g_lane
      assign lane_data[i] = dr_is_data(word[2*i+1 -: 2]);
      assign lane_null[i] = (word[2*i+1 -: 2] == DR_NULL);
    end
  endgenerate

  assign all_data = &lane_data;
  assign all_null = &lane_null;
endmodule

// File: rtl/dr_gate_array.sv
module dr_gate_array
  import dr_pkg::*;
#(
  parameter int NBITS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*NBITS-1:0] a_in,
  input  logic [2*NBITS-1:0] b_in,
  input  logic [2*NBITS-1:0] c_in,
  output logic [2*NBITS-1:0] y_out,
  output logic               data_done,
  output logic               null_done,
  output logic               ack,
  output logic               err
);
  localparam int WIDTH = 2 * NBITS;

  logic [WIDTH-1:0] y_w;
  logic [NBITS-1:0] lane_bad;
  logic             data_all, null_all;
  logic             ack_q, err_q;

  generate
    for (genvar i = 0; i < NBITS; i++) begin : g_lane
      dr_t and_y, c_inv, or_y;

      dr_th_gate #(.OP(OP_AND)) u_and (
        .clk(clk), .rst(rst),
        .x0(a_in[2*i+1 -: 2]), .x1(b_in[2*i+1 -: 2]), .y(and_y)
      );

      dr_inv u_inv (.x(c_in[2*i+1 -: 2]), .y(c_inv));

      dr_th_gate #(.OP(OP_OR)) u_or (
        .clk(clk), .rst(rst),
        .x0(and_y), .x1(c_inv), .y(or_y)
      );

      assign y_w[2*i+1 -: 2] = or_y;
      assign lane_bad[i] = (a_in[2*i+1 -: 2] == DR_BAD) ||
                           (b_in[2*i+1 -: 2] == DR_BAD) ||
                           (c_in[2*i+1 -: 2] == DR_BAD);
    end
  endgenerate

  dr_completion #(.NBITS(NBITS)) u_done (
    .word(y_w), .all_data(data_all), .all_null(null_all)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (data_all)      ack_q <= 1'b1;
      else if (null_all) ack_q <= 1'b0;
      if (|lane_bad)     err_q <= 1'b1;
    end
  end

  assign y_out     = y_w;
  assign data_done = data_all;
  assign null_done = null_all;
  assign ack       = ack_q;
  assign err       = err_q;

  // R7
  property ack_rise_p;
    @(posedge clk) disable iff (rst) $rose(ack_q) |-> $past(data_all);
  endproperty
  ack_rise_chk: assert property (ack_rise_p);

  // R7
  property ack_fall_p;
    @(posedge clk) disable iff (rst) $fell(ack_q) |-> $past(null_all);
  endproperty
  ack_fall_chk: assert property (ack_fall_p);

  // R8
  property err_sticky_p;
    @(posedge clk) disable iff (rst) err_q |=> err_q;
  endproperty
  err_sticky_chk: assert property (err_sticky_p);
endmodule

// File: tb/tb_dr_gate_array.sv
module tb_dr_gate_array;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, b_in, c_in, y_out;
  logic data_done, null_done, ack, err;

  int checks = 0;
  int fails = 0;
  int rail_bad = 0;
  logic [W-1:0] y_prev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dr_gate_array #(.NBITS(N)) dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .y_out(y_out), .data_done(data_done), .null_done(null_done),
    .ack(ack), .err(err)
  );

  function automatic logic [W-1:0] enc(logic [N-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < N; i++) r[2*i+1 -: 2] = v[i] ? 2'b01 : 2'b10;
    return r;
  endfunction

  function automatic logic [W-1:0] model(logic [N-1:0] a, logic [N-1:0] b, logic [N-1:0] c);
    return enc((a & b) | ~c);
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R9: watch each lane between consecutive cycles
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < N; i++) begin
        if ($countones(y_out[2*i+1 -: 2] ^ y_prev[2*i+1 -: 2]) > 1 ||
            y_out[2*i+1 -: 2] == 2'b11) rail_bad++;
      end
    end
    y_prev = y_out;
  end

  task automatic go_null();
    a_in = '0; b_in = '0; c_in = '0;
    step(4);
  endtask

  task automatic t_reset();
    chk("R1 y_out", y_out, '0);
    chk("R1 null_done", null_done, 1);
    chk("R1 data_done", data_done, 0);
    chk("R1 ack", ack, 0);
    chk("R1 err", err, 0);
  endtask

  task automatic t_wave(logic [N-1:0] a, logic [N-1:0] b, logic [N-1:0] c, string req);
    a_in = enc(a); b_in = enc(b); c_in = enc(c);
    step(4);
    chk(req, y_out, model(a, b, c));
    chk("R6 data_done", data_done, 1);
    chk("R7 ack high", ack, 1);
    go_null();
    chk("R4 back to null", y_out, '0);
    chk("R6 null_done", null_done, 1);
    chk("R7 ack low", ack, 0);
  endtask

  task automatic t_truth();
    t_wave(4'b1010, 4'b1100, 4'b1111, "R2 pattern0");
    t_wave(4'b1111, 4'b1111, 4'b0000, "R2 pattern1");
    t_wave(4'b0110, 4'b0101, 4'b1010, "R2 pattern2");
    t_wave(4'b0000, 4'b0000, 4'b0110, "R5 inverter");
  endtask

  task automatic t_partial();
    a_in = enc(4'b1111);
    step(5);
    chk("R3 only a", y_out, '0);
    chk("R7 ack hold low", ack, 0);
    b_in = enc(4'b1011);
    step(5);
    chk("R3 a and b", y_out, '0);
    c_in = enc(4'b1100);
    step(4);
    chk("R3 all arrived", y_out, model(4'b1111, 4'b1011, 4'b1100));
    a_in = '0;
    step(5);
    chk("R4 partial release", y_out, model(4'b1111, 4'b1011, 4'b1100));
    chk("R7 ack hold high", ack, 1);
    b_in = '0;
    step(5);
    chk("R4 c still data", y_out, model(4'b1111, 4'b1011, 4'b1100));
    c_in = '0;
    step(4);
    chk("R4 released", y_out, '0);
    chk("R7 ack released", ack, 0);
  endtask

  task automatic t_mixed_word();
    a_in = 8'b0000_0001; b_in = 8'b0000_0001; c_in = 8'b0000_0001;
    step(4);
    chk("R6 lane0 only", y_out, 8'b0000_0001);
    chk("R6 data_done mixed", data_done, 0);
    chk("R6 null_done mixed", null_done, 0);
    chk("R7 ack mixed", ack, 0);
    go_null();
  endtask

  task automatic t_illegal();
    a_in = enc(4'b1111); b_in = enc(4'b1111); c_in = enc(4'b1111);
    step(4);
    c_in[1:0] = 2'b11;
    step(4);
    chk("R8 hold on illegal", y_out, enc(4'b1111));
    chk("R8 err set", err, 1);
    go_null();
    a_in[1:0] = 2'b11;
    step(3);
    chk("R8 null held", y_out, '0);
    a_in = '0;
    step(3);
    chk("R8 err sticky", err, 1);
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(1);
    chk("R8 err cleared by reset", err, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; a_in = '0; b_in = '0; c_in = '0;
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_truth();
    t_partial();
    t_mixed_word();
    t_illegal();
    chk("R9 rail changes", rail_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule